// File: doc/BRIEF.md
# Programmable Block-Scan Address Generator

This block produces linear addresses for a video field held in memory. The field can be walked in plain raster order or as a series of rectangular tiles. A producer such as a camera can store a field line by line, and a compressor can then fetch the same field tile by tile, or the other way round. The block has two counter sets: a store side and a fetch side. Each side has its own field and tile geometry, loaded through a small register port, so the two sides can scan the same memory in different orders.

Each side has a start command, a per-start mode bit and a pixel-rate enable. The enable marks the cycles on which the consumer takes the presented address. In continuous mode one start walks tiles back to back until the field ends. In single mode one start yields exactly one tile. A tile ends with an end-of-tile pulse and a field ends with an end-of-field pulse. On the fetch side, a one-pixel pulse marks the first sample taken after an accepted start. Memory timing, refresh and data packing are not part of this block.

Top module: `blkscan_agen`

## Requirements
- R1: A configuration write with `cfg_we` high selects a side with `cfg_side` (0 = store side, 1 = fetch side) and a field with `cfg_sel` (0 field width, 1 field height, 2 tile width, 3 tile height). If that side is idle, the value is loaded and the side's position counters return to the field origin. If that side is active, the write is ignored.
- R2: The pixel with index n of a walk has the address (tile_row*tile_h + r)*field_w + tile_col*tile_w + c. Pixels run left to right and then top to bottom inside a tile. Tiles run left to right across a tile row, and tile rows run top to bottom.
- R3: The end-of-tile output is high, combinationally and for that cycle only, on a cycle where the pixel enable is high and the presented address is the last pixel of a tile.
- R4: The end-of-field output is high on the enabled cycle that presents the last pixel of the field. The following address is 0.
- R5: Counters advance only on cycles where the side is active and its pixel enable is high. On any other cycle the address holds and the framing outputs stay low.
- R6: In continuous mode (mode bit 0 at start), tiles follow one another with no gap. The side returns to idle after the end-of-field pixel.
- R7: In single mode (mode bit 1 at start), the side returns to idle after the end-of-tile pixel. The next start resumes at the next tile.
- R8: The fetch side's first-sample output is high only on the first enabled cycle after an accepted start.
- R9: A start while the side is idle and its geometry is invalid is ignored and sets that side's error flag. Invalid means any dimension is zero, or a field dimension is not a multiple of the matching tile dimension. An accepted start clears the flag.
- R10: A start while the side is already active has no effect on the walk in progress.
- R11: A synchronous active-high reset makes both sides idle, sets all counters to the origin, clears the error flags and sets the geometry to zero.
- R12: The two sides are independent. Activity, configuration or errors on one side do not change the other side's addresses or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Geometry write strobe |
| cfg_side | input | 1 | Target side: 0 store, 1 fetch |
| cfg_sel | input | 2 | Geometry field select |
| cfg_data | input | DIM_W | Geometry value |
| st_start | input | 1 | Store side start command |
| st_single | input | 1 | Store side mode at start: 1 single tile |
| st_pix_en | input | 1 | Store side pixel enable |
| st_addr | output | 2*DIM_W | Store side address |
| st_active | output | 1 | Store side walking |
| st_eot | output | 1 | Store side end of tile |
| st_eof | output | 1 | Store side end of field |
| st_err | output | 1 | Store side rejected-start flag |
| fe_start | input | 1 | Fetch side start command |
| fe_single | input | 1 | Fetch side mode at start: 1 single tile |
| fe_pix_en | input | 1 | Fetch side pixel enable |
| fe_addr | output | 2*DIM_W | Fetch side address |
| fe_active | output | 1 | Fetch side walking |
| fe_first | output | 1 | Fetch side first-sample pulse |
| fe_eot | output | 1 | Fetch side end of tile |
| fe_eof | output | 1 | Fetch side end of field |
| fe_err | output | 1 | Fetch side rejected-start flag |

## Verification
The address and the framing pulses are combinational from the counters. They are due in the same cycle as the pixel enable that consumes them, so the bench drives inputs on the falling edge and samples a short time later, before the next rising edge. A start, a configuration write or a final pixel changes the active bit, the error flag, the counters and the stored geometry only at the next rising edge, so the bench checks these on the following falling-edge sample. Each walk is compared pixel by pixel with an address derived arithmetically from the pixel index. Stall cycles and no-effect stimuli are checked by showing that the address is unchanged.

// File: rtl/blkscan_pkg.sv
package blkscan_pkg;
   typedef enum logic [1:0] {
      GSEL_FIELD_W = 2'd0,
      GSEL_FIELD_H = 2'd1,
      GSEL_TILE_W  = 2'd2,
      GSEL_TILE_H  = 2'd3
   } geom_sel_e;

   localparam int SIDE_STORE = 0;
   localparam int SIDE_FETCH = 1;
   localparam int NUM_SIDES  = 2;
endpackage

// File: rtl/blkscan_geom.sv
module blkscan_geom
   import blkscan_pkg::*;
#(
   parameter int DIM_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [1:0]       sel,
   input  logic [DIM_W-1:0] data,
   input  logic             busy,
   output logic [DIM_W-1:0] field_w,
   output logic [DIM_W-1:0] field_h,
   output logic [DIM_W-1:0] tile_w,
   output logic [DIM_W-1:0] tile_h,
   output logic             geom_ok,
   output logic             origin_clr
);
   logic take;
   assign take       = we && !busy;
   assign origin_clr = take;

   always_ff @(posedge clk) begin
      if (rst) begin
         field_w <= '0;
         field_h <= '0;
         tile_w  <= '0;
         tile_h  <= '0;
      end else if (take) begin
         unique case (geom_sel_e'(sel))
            GSEL_FIELD_W: field_w <= data;
            GSEL_FIELD_H: field_h <= data;
            GSEL_TILE_W:  tile_w  <= data;
            GSEL_TILE_H:  tile_h  <= data;
         endcase
      end
   end

   logic dims_nonzero;
   assign dims_nonzero = (field_w != '0) && (field_h != '0) &&
                         (tile_w  != '0) && (tile_h  != '0);

   always_comb begin
      geom_ok = 1'b0;
      if (dims_nonzero)
         geom_ok = ((field_w % tile_w) == '0) && ((field_h % tile_h) == '0);
   end

   assert_locked_R1: assert property (@(posedge clk) disable iff (rst)
      we && busy |=> $stable({field_w, field_h, tile_w, tile_h}));
endmodule

// File: rtl/blkscan_walker.sv
module blkscan_walker #(
   parameter int DIM_W      = 8,
   parameter int ADDR_W     = 2 * DIM_W,
   parameter bit EMIT_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              origin_clr,
   input  logic              start,
   input  logic              single_in,
   input  logic              pix_en,
   input  logic [DIM_W-1:0]  field_w,
   input  logic [DIM_W-1:0]  field_h,
   input  logic [DIM_W-1:0]  tile_w,
   input  logic [DIM_W-1:0]  tile_h,
   input  logic              geom_ok,
   output logic [ADDR_W-1:0] addr,
   output logic              active,
   output logic              first,
   output logic              eot,
   output logic              eof,
   output logic              err
);
   localparam int SUM_W = DIM_W + 1;

   logic [DIM_W-1:0] col_q, row_q, xbase_q, ybase_q;
   logic             single_q;

   logic last_col, last_row, last_tx, last_ty, step, accept;
   logic [SUM_W-1:0] x_next, y_next;

   assign x_next   = {1'b0, xbase_q} + {1'b0, tile_w};
   assign y_next   = {1'b0, ybase_q} + {1'b0, tile_h};
   assign last_col = (col_q == tile_w - DIM_W'(1));
   assign last_row = (row_q == tile_h - DIM_W'(1));
   assign last_tx  = (x_next == {1'b0, field_w});
   assign last_ty  = (y_next == {1'b0, field_h});
   assign step     = active && pix_en;
   assign accept   = start && !active && geom_ok;

   assign eot = step && last_col && last_row;
   assign eof = eot && last_tx && last_ty;

   logic [ADDR_W-1:0] line_idx;
   assign line_idx = ADDR_W'(ybase_q) + ADDR_W'(row_q);
   assign addr     = line_idx * ADDR_W'(field_w) + ADDR_W'(xbase_q) + ADDR_W'(col_q);

   always_ff @(posedge clk) begin
      if (rst || origin_clr) begin
         col_q   <= '0;
         row_q   <= '0;
         xbase_q <= '0;
         ybase_q <= '0;
      end else if (step) begin
         if (!last_col) begin
            col_q <= col_q + DIM_W'(1);
         end else begin
            col_q <= '0;
            if (!last_row) begin
               row_q <= row_q + DIM_W'(1);
            end else begin
               row_q <= '0;
               if (!last_tx) begin
                  xbase_q <= x_next[DIM_W-1:0];
               end else begin
                  xbase_q <= '0;
                  ybase_q <= last_ty ? '0 : y_next[DIM_W-1:0];
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         active   <= 1'b0;
         single_q <= 1'b0;
         err      <= 1'b0;
      end else begin
         if (accept) begin
            active   <= 1'b1;
            single_q <= single_in;
            err      <= 1'b0;
         end else if (start && !active) begin
            err <= 1'b1;
         end else if (step && (eof || (single_q && eot))) begin
            active <= 1'b0;
         end
      end
   end

   generate
      if (EMIT_FIRST) begin : g_first
         logic pend_q;
         always_ff @(posedge clk) begin
            if (rst)         pend_q <= 1'b0;
            else if (accept) pend_q <= 1'b1;
            else if (step)   pend_q <= 1'b0;
         end
         assign first = step && pend_q;

         assert_first_once_R8: assert property (@(posedge clk) disable iff (rst)
            first |=> !first);
      end else begin : g_no_first
         assign first = 1'b0;
      end
   endgenerate

   assert_stall_R5: assert property (@(posedge clk) disable iff (rst)
      active && !pix_en && !origin_clr |=> $stable(addr));
   assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      eof |=> (addr == '0));
   assert_field_stop_R6: assert property (@(posedge clk) disable iff (rst)
      eof |=> !active);
   assert_single_stop_R7: assert property (@(posedge clk) disable iff (rst)
      eot && single_q |=> !active);
   assert_reject_R9: assert property (@(posedge clk) disable iff (rst)
      start && !active && !geom_ok |=> !active && err);
   assert_eof_in_tile_R3: assert property (@(posedge clk) disable iff (rst)
      eof |-> eot);
endmodule

// File: rtl/blkscan_agen.sv
module blkscan_agen
   import blkscan_pkg::*;
#(
   parameter int DIM_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cfg_we,
   input  logic               cfg_side,
   input  logic [1:0]         cfg_sel,
   input  logic [DIM_W-1:0]   cfg_data,
   input  logic               st_start,
   input  logic               st_single,
   input  logic               st_pix_en,
   output logic [2*DIM_W-1:0] st_addr,
   output logic               st_active,
   output logic               st_eot,
   output logic               st_eof,
   output logic               st_err,
   input  logic               fe_start,
   input  logic               fe_single,
   input  logic               fe_pix_en,
   output logic [2*DIM_W-1:0] fe_addr,
   output logic               fe_active,
   output logic               fe_first,
   output logic               fe_eot,
   output logic               fe_eof,
   output logic               fe_err
);
   localparam int ADDR_W = 2 * DIM_W;

   if (DIM_W < 2)  $error("DIM_W must be at least 2");
   if (DIM_W > 16) $error("DIM_W above 16 makes the address multiplier too wide");

   logic              s_start  [NUM_SIDES];
   logic              s_single [NUM_SIDES];
   logic              s_pix    [NUM_SIDES];
   logic [ADDR_W-1:0] s_addr   [NUM_SIDES];
   logic              s_active [NUM_SIDES];
   logic              s_first  [NUM_SIDES];
   logic              s_eot    [NUM_SIDES];
   logic              s_eof    [NUM_SIDES];
   logic              s_err    [NUM_SIDES];

   assign s_start[SIDE_STORE]  = st_start;
   assign s_single[SIDE_STORE] = st_single;
   assign s_pix[SIDE_STORE]    = st_pix_en;
   assign s_start[SIDE_FETCH]  = fe_start;
   assign s_single[SIDE_FETCH] = fe_single;
   assign s_pix[SIDE_FETCH]    = fe_pix_en;

   for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
      logic [DIM_W-1:0] fw, fh, tw, th;
      logic             ok, clr;

      blkscan_geom #(.DIM_W(DIM_W)) u_geom (
         .clk       (clk),
         .rst       (rst),
         .we        (cfg_we && (cfg_side == 1'(g))),
         .sel       (cfg_sel),
         .data      (cfg_data),
         .busy      (s_active[g]),
         .field_w   (fw),
         .field_h   (fh),
         .tile_w    (tw),
         .tile_h    (th),
         .geom_ok   (ok),
         .origin_clr(clr)
      );

      blkscan_walker #(
         .DIM_W     (DIM_W),
         .ADDR_W    (ADDR_W),
         .EMIT_FIRST(g == SIDE_FETCH)
      ) u_walk (
         .clk       (clk),
         .rst       (rst),
         .origin_clr(clr),
         .start     (s_start[g]),
         .single_in (s_single[g]),
         .pix_en    (s_pix[g]),
         .field_w   (fw),
         .field_h   (fh),
         .tile_w    (tw),
         .tile_h    (th),
         .geom_ok   (ok),
         .addr      (s_addr[g]),
         .active    (s_active[g]),
         .first     (s_first[g]),
         .eot       (s_eot[g]),
         .eof       (s_eof[g]),
         .err       (s_err[g])
      );
   end

   assign st_addr   = s_addr[SIDE_STORE];
   assign st_active = s_active[SIDE_STORE];
   assign st_eot    = s_eot[SIDE_STORE];
   assign st_eof    = s_eof[SIDE_STORE];
   assign st_err    = s_err[SIDE_STORE];
   assign fe_addr   = s_addr[SIDE_FETCH];
   assign fe_active = s_active[SIDE_FETCH];
   assign fe_first  = s_first[SIDE_FETCH];
   assign fe_eot    = s_eot[SIDE_FETCH];
   assign fe_eof    = s_eof[SIDE_FETCH];
   assign fe_err    = s_err[SIDE_FETCH];

   assert_store_quiet_R12: assert property (@(posedge clk) disable iff (rst)
      !st_active && !st_start && !(cfg_we && !cfg_side) |=> $stable(st_addr));
endmodule

// File: tb/blkscan_agen_tb.sv
module blkscan_agen_tb;
   localparam int DW = 6;
   localparam int AW = 2 * DW;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic          cfg_we = 0, cfg_side = 0;
   logic [1:0]    cfg_sel = 0;
   logic [DW-1:0] cfg_data = 0;
   logic st_start = 0, st_single = 0, st_pix_en = 0;
   logic fe_start = 0, fe_single = 0, fe_pix_en = 0;
   logic [AW-1:0] st_addr, fe_addr;
   logic st_active, st_eot, st_eof, st_err;
   logic fe_active, fe_first, fe_eot, fe_eof, fe_err;

   blkscan_agen #(.DIM_W(DW)) u_dut (.*);

   int checks = 0, errors = 0;
   int gfw[2], gfh[2], gtw[2], gth[2];
   int cur = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_addr(input int s, input int n);
      int per_tile = gtw[s] * gth[s];
      int tiles_x  = gfw[s] / gtw[s];
      int t = n / per_tile, i = n % per_tile;
      return ((t / tiles_x) * gth[s] + i / gtw[s]) * gfw[s] + (t % tiles_x) * gtw[s] + i % gtw[s];
   endfunction

   function automatic int o_addr();   return cur ? int'(fe_addr) : int'(st_addr); endfunction
   function automatic bit o_active(); return cur ? fe_active : st_active; endfunction
   function automatic bit o_eot();    return cur ? fe_eot : st_eot; endfunction
   function automatic bit o_eof();    return cur ? fe_eof : st_eof; endfunction
   function automatic bit o_err();    return cur ? fe_err : st_err; endfunction
   function automatic bit o_first();  return cur ? fe_first : 1'b0; endfunction

   task automatic drive(input bit s, input bit sg, input bit pe);
      if (cur) begin fe_start = s; fe_single = sg; fe_pix_en = pe; end
      else     begin st_start = s; st_single = sg; st_pix_en = pe; end
   endtask

   task automatic cfg(input int side, input int sel, input int val);
      @(negedge clk);
      cfg_we = 1; cfg_side = side[0]; cfg_sel = sel[1:0]; cfg_data = val[DW-1:0];
      @(negedge clk);
      cfg_we = 0;
      case (sel)
         0: gfw[side] = val;
         1: gfh[side] = val;
         2: gtw[side] = val;
         default: gth[side] = val;
      endcase
   endtask

   // walk count pixels from index n0; gap>0 stalls every gap-th cycle; poke tests busy writes/starts
   task automatic run(input int side, input bit single, input int n0, input int count,
                      input int gap, input bit poke);
      int total, k, cyc;
      cur = side;
      total = gfw[side] * gfh[side];
      @(negedge clk);
      drive(1, single, 0);
      @(negedge clk);
      drive(0, 0, 0);
      #2;
      chk(o_active() == 1, "R6 start accepted", o_active(), 1);
      chk(o_err() == 0, "R9 accepted start clears error", o_err(), 0);
      k = 0; cyc = 0;
      while (k < count) begin
         bit pe;
         int idx;
         if (cyc != 0) @(negedge clk);
         pe = (gap == 0) || ((cyc % gap) != gap - 1);
         drive(poke && cyc == 3, 0, pe);
         cfg_we = poke && cyc == 3; cfg_side = side[0]; cfg_sel = 0; cfg_data = 6'd16;
         #2;
         idx = (n0 + k) % total;
         chk(o_addr() == exp_addr(side, idx), pe ? "R2 address" : "R5 stall holds address",
             o_addr(), exp_addr(side, idx));
         if (pe) begin
            chk(o_eot() == (((idx + 1) % (gtw[side] * gth[side])) == 0), "R3 end of tile",
                o_eot(), ((idx + 1) % (gtw[side] * gth[side])) == 0);
            chk(o_eof() == (idx == total - 1), "R4 end of field", o_eof(), idx == total - 1);
            chk(o_first() == (side == 1 && k == 0), "R8 first sample", o_first(),
                side == 1 && k == 0);
            k++;
         end else begin
            chk(!o_eot() && !o_eof() && !o_first(), "R5 stall framing low",
                o_eot() + o_eof() + o_first(), 0);
         end
         cyc++;
      end
      @(negedge clk);
      drive(0, 0, 0);
      cfg_we = 0;
      #2;
      chk(o_active() == 0, single ? "R7 single tile stops" : "R6 field end stops", o_active(), 0);
      chk(o_addr() == exp_addr(side, (n0 + count) % total), "R4 R7 next position",
          o_addr(), exp_addr(side, (n0 + count) % total));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      gfw = '{0, 0}; gfh = '{0, 0}; gtw = '{0, 0}; gth = '{0, 0};
      repeat (3) @(negedge clk);
      rst = 0;
      #2;
      chk(!st_active && !fe_active, "R11 idle after reset", st_active + fe_active, 0);
      chk(st_addr == 0 && fe_addr == 0, "R11 origin after reset", int'(st_addr | fe_addr), 0);
      chk(!st_err && !fe_err && !fe_first && !fe_eot && !st_eof, "R11 flags clear",
          st_err + fe_err, 0);

      // zero geometry: rejected start
      @(negedge clk); fe_start = 1;
      @(negedge clk); fe_start = 0; #2;
      chk(fe_err == 1 && fe_active == 0, "R9 zero geometry rejected", fe_err, 1);
      chk(st_err == 0 && st_active == 0, "R12 store side untouched", st_err, 0);

      cfg(0, 0, 8); cfg(0, 1, 4); cfg(0, 2, 8); cfg(0, 3, 1);
      cfg(1, 0, 8); cfg(1, 1, 4); cfg(1, 2, 4); cfg(1, 3, 2);
      chk(fe_err == 1, "R12 store config leaves fetch error", fe_err, 1);

      run(0, 0, 0, 32, 0, 0);               // raster on store side
      run(1, 0, 0, 32, 3, 1);               // tiles with stalls, busy write and start (R1 R10)
      run(1, 0, 0, 32, 0, 0);               // geometry unchanged by busy write (R1)

      run(1, 1, 0, 8, 2, 0);                // single tiles
      run(0, 0, 0, 32, 4, 0);               // other side between tiles (R12)
      run(1, 1, 8, 8, 0, 0);
      run(1, 1, 16, 8, 0, 0);
      run(1, 1, 24, 8, 0, 0);               // last tile carries end of field
      run(1, 1, 0, 8, 0, 0);                // resumes at origin after wrap

      // idle write clears origin (R1) then invalid geometry (R9)
      cfg(1, 0, 6);
      cur = 1; #2;
      chk(fe_addr == 0, "R1 idle write returns to origin", int'(fe_addr), 0);
      @(negedge clk); fe_start = 1;
      @(negedge clk); fe_start = 0; #2;
      chk(fe_err == 1 && fe_active == 0, "R9 non-multiple width rejected", fe_err, 1);
      cfg(1, 0, 8);
      run(1, 0, 0, 32, 0, 0);

      // tall narrow tiles
      cfg(1, 2, 2); cfg(1, 3, 4);
      run(1, 0, 0, 32, 4, 0);
      cfg(1, 3, 3);
      @(negedge clk); fe_start = 1;
      @(negedge clk); fe_start = 0; #2;
      chk(fe_err == 1, "R9 non-multiple height rejected", fe_err, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule